// File: doc/BRIEF.md
# SPI Word Transfer Engine

This block sits between a producer and a consumer of data words and a serial peripheral. Words pushed into a transmit queue are sent one at a time over a master-mode serial link (clock idles low, data launched on the falling clock edge, input captured on the rising edge). The word clocked in from the peripheral is placed in a receive queue, where the consumer pops it. Both queues hold eight words of up to sixteen bits, and their fill levels are visible at the ports.

A 4-bit size code selects a word length from 1 to 16 bits. Data is trimmed to that length when it enters either queue. A loopback control bypasses the serial pins: each queued transmit word moves straight into the receive queue in a single cycle. The engine never lets the receive queue overflow. If the receive queue is full, transmission pauses and resumes one cycle after the consumer frees a slot. The serial clock half-period comes from a prescaler input, with a floor of two system clocks.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset both counts read 0, `cs_n` is 1, `sclk` is 0 and `rx_data` is 0.
- R2: Words leave the receive side in the order they were pushed. A pushed word is trimmed to its low `size_code`+1 bits, using the size code present at the push.
- R3: A push while `tx_count` is 8 is dropped. The count stays at 8 and the dropped word never reaches the receive side.
- R4: While `rx_count` is 8 no word leaves the transmit queue, and `rx_count` never exceeds 8.
- R5: While `enable` is 0 no word is started. `cs_n` stays 1 and queued words are kept.
- R6: With `loopback` at 1, one word per cycle moves from the transmit to the receive queue. `cs_n` and `sclk` stay idle.
- R7: While the receive queue is empty, `rx_data` is 0 and a pop leaves `rx_count` at 0.
- R8: A serial word is size_code+1 bits, most significant bit first. `mosi` changes only where `sclk` falls, `miso` is captured where `sclk` rises, and `sclk` is 0 whenever `cs_n` is 1.
- R9: Every `sclk` phase lasts max(`prescale`, 2) clock cycles.
- R10: `cs_n` goes low once per word and returns high after each word.
- R11: When the receive queue is full and a word is waiting, a pop lets that word move on the following clock edge.
- R12: A word entering the receive queue is trimmed to the size code in force at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_push | input | 1 | Write strobe for the transmit queue |
| tx_data | input | WORD_W | Word to queue for transmission |
| rx_pop | input | 1 | Removes the oldest received word |
| rx_data | output | WORD_W | Oldest received word, 0 when empty |
| enable | input | 1 | Permits new transfers to start |
| loopback | input | 1 | Routes transmit words internally to the receive queue |
| size_code | input | CODE_W | Word length minus one |
| prescale | input | PRE_W | Serial clock half-period in system clocks |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low during each word |
| miso | input | 1 | Serial data in |
| tx_count | output | CNT_W | Words held in the transmit queue |
| rx_count | output | CNT_W | Words held in the receive queue |

## Verification
The bench builds the block with its defaults: 16-bit words, eight-entry queues and an 8-bit prescaler. This makes every size code from 0 to 15 available for sweeps in both loopback and serial mode, and lets both queues be filled to their limit of eight. Prescaler values 0, 1, 2, 3 and 5 cover the clamped and the direct half-period cases. A peripheral model returns a known pattern, so each received word can be predicted by masking that pattern with the word length.

// File: rtl/spi_xfer_pkg.sv
`timescale 1ns/1ps
package spi_xfer_pkg;

   // Shortest serial clock phase, in system clocks.
   localparam int unsigned SPIX_MIN_HALF = 2;

   // Returns a vector with its n lowest bits set.
   function automatic logic [31:0] low_ones(input int unsigned n);
      logic [31:0] m;
      m = '0;
      for (int unsigned i = 0; i < 32; i++) begin
         if (i < n) m[i] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/spi_word_fifo.sv
`timescale 1ns/1ps
module spi_word_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     rdata,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spi_word_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt_q;
   logic             do_push, do_pop;
   logic [W-1:0]     slots [DEPTH];

   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic [W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (do_push && wr_ptr == PTR_W'(e)) slot_q <= wdata;
      end
      assign slots[e] = slot_q;
   end

   assign rdata = slots[rd_ptr];
   assign count = cnt_q;

endmodule

// File: rtl/spi_shift_master.sv
`timescale 1ns/1ps
module spi_shift_master
   import spi_xfer_pkg::*;
#(
   parameter int W      = 16,
   parameter int PRE_W  = 8,
   localparam int CODE_W = $clog2(W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [W-1:0]      word,
   input  logic [CODE_W-1:0] last_idx,
   input  logic [PRE_W-1:0]  half,
   input  logic              miso,
   output logic              busy,
   output logic              sclk,
   output logic              mosi,
   output logic              done,
   output logic [W-1:0]      rx_word
);

   localparam logic [CODE_W-1:0] TOP_IDX = CODE_W'(W - 1);
   localparam logic [PRE_W-1:0]  FLOOR   = PRE_W'(SPIX_MIN_HALF);

   logic [PRE_W-1:0]  hp_q, div_q;
   logic [CODE_W-1:0] left_q;
   logic [W-1:0]      out_q, in_q;
   logic              busy_q, sclk_q, tick;

   assign tick = busy_q && (div_q == hp_q - 1'b1);
   assign done = tick && sclk_q && (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         hp_q   <= FLOOR;
         div_q  <= '0;
         left_q <= '0;
         out_q  <= '0;
         in_q   <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         sclk_q <= 1'b0;
         div_q  <= '0;
         left_q <= last_idx;
         hp_q   <= (half < FLOOR) ? FLOOR : half;
         out_q  <= word << (TOP_IDX - last_idx);
         in_q   <= '0;
      end else if (busy_q) begin
         if (tick) begin
            div_q <= '0;
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               in_q   <= {in_q[W-2:0], miso};
            end else begin
               sclk_q <= 1'b0;
               if (left_q == '0) begin
                  busy_q <= 1'b0;
               end else begin
                  left_q <= left_q - 1'b1;
                  out_q  <= out_q << 1;
               end
            end
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

   assign busy    = busy_q;
   assign sclk    = sclk_q;
   assign mosi    = busy_q & out_q[W-1];
   assign rx_word = in_q;

endmodule

// File: rtl/spi_xfer_engine.sv
`timescale 1ns/1ps
module spi_xfer_engine
   import spi_xfer_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 8,
   parameter int PRE_W  = 8,
   localparam int CODE_W = $clog2(WORD_W),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_push,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              rx_pop,
   output logic [WORD_W-1:0] rx_data,
   input  logic              enable,
   input  logic              loopback,
   input  logic [CODE_W-1:0] size_code,
   input  logic [PRE_W-1:0]  prescale,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_n,
   input  logic              miso,
   output logic [CNT_W-1:0]  tx_count,
   output logic [CNT_W-1:0]  rx_count
);

   if (WORD_W < 2 || WORD_W > 32) begin : g_bad_width
      $error("spi_xfer_engine: WORD_W must lie in 2..32");
   end
   if (PRE_W < 2) begin : g_bad_pre
      $error("spi_xfer_engine: PRE_W must be at least 2");
   end

   logic [WORD_W-1:0] word_mask, tx_head, rx_head, sh_rx, rx_wdata;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic              go, sh_start, sh_busy, sh_done, rx_put;

   assign word_mask = WORD_W'(low_ones(32'(size_code) + 32'd1));

   // A word may leave only when the receive side can take it.
   assign go       = enable && !tx_empty && !rx_full && !sh_busy;
   assign sh_start = go && !loopback;
   assign rx_put   = (go && loopback) || sh_done;
   assign rx_wdata = (sh_done ? sh_rx : tx_head) & word_mask;

   spi_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push),
      .pop   (go),
      .wdata (tx_data & word_mask),
      .rdata (tx_head),
      .count (tx_count),
      .full  (tx_full),
      .empty (tx_empty)
   );

   spi_word_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_put),
      .pop   (rx_pop),
      .wdata (rx_wdata),
      .rdata (rx_head),
      .count (rx_count),
      .full  (rx_full),
      .empty (rx_empty)
   );

   spi_shift_master #(.W(WORD_W), .PRE_W(PRE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (sh_start),
      .word     (tx_head),
      .last_idx (size_code),
      .half     (prescale),
      .miso     (miso),
      .busy     (sh_busy),
      .sclk     (sclk),
      .mosi     (mosi),
      .done     (sh_done),
      .rx_word  (sh_rx)
   );

   assign cs_n    = ~sh_busy;
   assign rx_data = rx_empty ? '0 : rx_head;

   // The transmit-full flag only gates pushes inside the queue.
   logic unused_tx_full;
   assign unused_tx_full = tx_full;

endmodule

// File: rtl/spi_xfer_engine_chk.sv
`timescale 1ns/1ps
module spi_xfer_engine_chk #(
   parameter int DEPTH = 8,
   parameter int PRE_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int RW    = PRE_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic [PRE_W-1:0] prescale,
   input logic [CNT_W-1:0] tx_count,
   input logic [CNT_W-1:0] rx_count,
   input logic             sclk,
   input logic             mosi,
   input logic             cs_n
);

   logic          sclk_d;
   logic [RW-1:0] run_q, hp_seen;

   // Cycles since the last serial clock edge, and the phase length expected
   // for the word in flight.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         run_q   <= '0;
         hp_seen <= RW'(2);
      end else begin
         sclk_d <= sclk;
         if (cs_n) begin
            run_q   <= '0;
            hp_seen <= (prescale < PRE_W'(2)) ? RW'(2) : {1'b0, prescale};
         end else if (sclk != sclk_d) begin
            run_q <= RW'(1);
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   a_r3_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= CNT_W'(DEPTH));

   a_r4_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= CNT_W'(DEPTH));

   a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == CNT_W'(DEPTH)) |=> (tx_count >= $past(tx_count)));

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && cs_n) |=> (cs_n && tx_count >= $past(tx_count)));

   a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   a_r8_mosi_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n) && !($past(sclk) && !sclk)) |-> $stable(mosi));

   a_r9_half_period: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && sclk != sclk_d) |-> (run_q == hp_seen));

endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.DEPTH(DEPTH), .PRE_W(PRE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .prescale (prescale),
   .tx_count (tx_count),
   .rx_count (rx_count),
   .sclk     (sclk),
   .mosi     (mosi),
   .cs_n     (cs_n)
);

// File: tb/spi_xfer_engine_bench.sv
`timescale 1ns/1ps
module spi_xfer_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_push = 1'b0;
   logic [15:0] tx_data = '0;
   logic        rx_pop = 1'b0;
   logic [15:0] rx_data;
   logic        enable = 1'b0;
   logic        loopback = 1'b0;
   logic [3:0]  size_code = 4'd15;
   logic [7:0]  prescale = 8'd2;
   logic        sclk, mosi, cs_n;
   logic        miso = 1'b0;
   logic [3:0]  tx_count, rx_count;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   spi_xfer_engine u_spi_xfer_engine (
      .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_data(tx_data),
      .rx_pop(rx_pop), .rx_data(rx_data), .enable(enable), .loopback(loopback),
      .size_code(size_code), .prescale(prescale), .sclk(sclk), .mosi(mosi),
      .cs_n(cs_n), .miso(miso), .tx_count(tx_count), .rx_count(rx_count)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Peripheral model and line monitors
   logic [15:0] slave_word = 16'h0;
   int          sidx = 0;
   logic [15:0] mosi_word = '0;
   int          nrise = 0;
   int          cs_falls = 0;
   int          cs_low_cycles = 0;
   int          sclk_high_cycles = 0;
   int          mosi_bad = 0;
   time         t_fall = 0, t_rise1 = 0;
   logic        pm = 1'b0, ps = 1'b0, pc = 1'b1;

   always @(negedge cs_n) begin
      cs_falls++;
      sidx = int'(size_code);
      miso = slave_word[sidx];
      mosi_word = '0;
      nrise = 0;
      t_fall = $time;
   end

   always @(negedge sclk) begin
      if (cs_n === 1'b0 && sidx > 0) begin
         sidx--;
         miso = slave_word[sidx];
      end
   end

   always @(posedge sclk) begin
      if (cs_n === 1'b0) begin
         mosi_word = {mosi_word[14:0], mosi};
         if (nrise == 0) t_rise1 = $time;
         nrise++;
      end
   end

   always @(negedge clk) begin
      if (cs_n === 1'b0) cs_low_cycles++;
      if (sclk === 1'b1) sclk_high_cycles++;
      if (pc === 1'b0 && cs_n === 1'b0 && mosi !== pm && !(ps === 1'b1 && sclk === 1'b0))
         mosi_bad++;
      pm = mosi;
      ps = sclk;
      pc = cs_n;
   end

   task automatic push(input logic [15:0] v);
      @(negedge clk);
      tx_push = 1'b1;
      tx_data = v;
      @(negedge clk);
      tx_push = 1'b0;
   endtask

   task automatic pop(output logic [15:0] v);
      @(negedge clk);
      v = rx_data;
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         if (tx_count == 4'd0 && cs_n === 1'b1) break;
      end
      @(negedge clk);
   endtask

   initial begin
      #1_000_000;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] r;
      logic [15:0] exp_q [11];
      int cs0, sh0, f0, m;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 tx_count", int'(tx_count), 0);
      chk("R1 rx_count", int'(rx_count), 0);
      chk("R1 cs_n", int'(cs_n), 1);
      chk("R1 sclk", int'(sclk), 0);
      chk("R1 rx_data", int'(rx_data), 0);

      // R7 pop from empty
      pop(r);
      chk("R7 empty data", int'(r), 0);
      chk("R7 empty count", int'(rx_count), 0);

      // R5 disabled: words stay queued, nothing starts
      cs0 = cs_low_cycles;
      push(16'h1111); push(16'h2222); push(16'h3333);
      repeat (30) @(negedge clk);
      chk("R5 tx kept", int'(tx_count), 3);
      chk("R5 rx empty", int'(rx_count), 0);
      chk("R5 no select", cs_low_cycles - cs0, 0);

      // R3 overflow of the transmit queue
      for (int i = 0; i < 5; i++) push(16'h4000 + 16'(i));
      chk("R3 full", int'(tx_count), 8);
      push(16'hDEAD);
      chk("R3 drop", int'(tx_count), 8);

      exp_q[0] = 16'h1111; exp_q[1] = 16'h2222; exp_q[2] = 16'h3333;
      for (int i = 0; i < 5; i++) exp_q[3 + i] = 16'h4000 + 16'(i);
      for (int i = 0; i < 3; i++) exp_q[8 + i] = 16'h5000 + 16'(i);

      // R6 loopback: one word per cycle, serial pins idle
      cs0 = cs_low_cycles;
      sh0 = sclk_high_cycles;
      loopback = 1'b1;
      enable = 1'b1;
      @(negedge clk);
      chk("R6 first move tx", int'(tx_count), 7);
      chk("R6 first move rx", int'(rx_count), 1);
      repeat (7) @(negedge clk);
      chk("R6 all moved tx", int'(tx_count), 0);
      chk("R4 rx at limit", int'(rx_count), 8);
      chk("R6 cs idle", cs_low_cycles - cs0, 0);
      chk("R6 sclk idle", sclk_high_cycles - sh0, 0);

      // R4 stall with receive queue full
      for (int i = 0; i < 3; i++) push(16'h5000 + 16'(i));
      repeat (10) @(negedge clk);
      chk("R4 stall tx", int'(tx_count), 3);
      chk("R4 stall rx", int'(rx_count), 8);

      // R11 resume one cycle after a pop
      @(negedge clk);
      r = rx_data;
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
      chk("R11 after pop tx", int'(tx_count), 3);
      chk("R11 after pop rx", int'(rx_count), 7);
      @(negedge clk);
      chk("R11 resumed tx", int'(tx_count), 2);
      chk("R11 resumed rx", int'(rx_count), 8);
      chk("R2 order 0", int'(r), int'(exp_q[0]));
      for (int i = 1; i < 11; i++) begin
         pop(r);
         chk($sformatf("R2 order %0d", i), int'(r), int'(exp_q[i]));
      end
      chk("R3 dropped word absent", int'(rx_count), 0);
      chk("R2 tx drained", int'(tx_count), 0);

      // R2 push-side trimming, all size codes
      for (int sc = 0; sc < 16; sc++) begin
         logic [15:0] v;
         size_code = 4'(sc);
         v = 16'(46809 ^ (sc * 273));
         m = (1 << (sc + 1)) - 1;
         push(v);
         pop(r);
         chk($sformatf("R2 mask code %0d", sc), int'(r), int'(v) & m);
      end

      // R12 receive-side trimming with a later, shorter size code
      enable = 1'b0;
      size_code = 4'd15;
      push(16'hFFFF);
      size_code = 4'd3;
      enable = 1'b1;
      @(negedge clk);
      @(negedge clk);
      pop(r);
      chk("R12 rx trim", int'(r), 16'h000F);

      // R8 / R12 serial words, all size codes
      loopback = 1'b0;
      prescale = 8'd2;
      for (int sc = 0; sc < 16; sc++) begin
         logic [15:0] v;
         size_code = 4'(sc);
         v = 16'(23130 ^ (sc * 4369));
         slave_word = 16'(51966 ^ (sc * 771));
         m = (1 << (sc + 1)) - 1;
         push(v);
         wait_idle();
         chk($sformatf("R8 bit count code %0d", sc), nrise, sc + 1);
         chk($sformatf("R8 mosi word code %0d", sc), int'(mosi_word), int'(v) & m);
         pop(r);
         chk($sformatf("R12 miso word code %0d", sc), int'(r), int'(slave_word) & m);
      end

      // R9 half period versus prescale
      size_code = 4'd0;
      for (int k = 0; k < 5; k++) begin
         int p;
         p = (k == 4) ? 5 : k;
         prescale = 8'(p);
         push(16'h0001);
         wait_idle();
         chk($sformatf("R9 half period p=%0d", p), int'((t_rise1 - t_fall) / 10), (p < 2) ? 2 : p);
         pop(r);
      end

      // R10 one select per word, back to back
      prescale = 8'd2;
      size_code = 4'd7;
      slave_word = 16'h00C3;
      f0 = cs_falls;
      push(16'h0081); push(16'h0042); push(16'h0024);
      wait_idle();
      chk("R10 select count", cs_falls - f0, 3);
      chk("R10 cs released", int'(cs_n), 1);
      chk("R10 words received", int'(rx_count), 3);
      for (int i = 0; i < 3; i++) begin
         pop(r);
         chk("R10 word data", int'(r), 16'h00C3);
      end

      chk("R8 mosi edges", mosi_bad, 0);
      chk("R8 sclk idle low", int'(sclk), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule